// File: doc/BRIEF.md
# Mask-Indexed GPIO Bank Controller

This block controls one bank of general-purpose I/O lines, 32 by default, through a small register bus. Per-line configuration is not reached by a line number. Software first writes a line-select mask. It then reads or writes one shared configuration register, and that access applies to every line the mask selects. Each line holds a 3-bit function selector and a direction bit. The function selector picks plain GPIO or one of seven alternate peripheral functions. The block exports every line's selector so that a pad-level multiplexer can route the peripheral signals.

Output levels change only through a set register and a clear register. Each of these acts on the lines whose written bit is 1. The pad output enable is raised for a line only when that line is a GPIO output. Pad inputs pass through a two-flop synchronizer before software can read them in the status register. Every register read returns its data one clock after the request.

Top module: `gpb_bank_top`

## Requirements
- R1: After reset the mask is 0, every line is GPIO (function 0) with direction 0, all output latches are 0, pad_oe is 0 and bus_rdata is 0.
- R2: A write to offset 0x00 loads the line-select mask (bit n selects line n). A read of offset 0x00 returns the mask.
- R3: A write to offset 0x04 stores function = wdata[2:0] and direction = wdata[8] into every line whose mask bit is 1. Lines whose mask bit is 0 keep their configuration.
- R4: Function code 0 is GPIO and codes 1 to 7 are alternate functions A to G. Line n's code appears on line_func[3n+2:3n] from the cycle after the write.
- R5: A write to offset 0x10 sets the output latch of each line whose written bit is 1. Bits written as 0 leave their latch unchanged.
- R6: A write to offset 0x14 clears the output latch of each line whose written bit is 1. Bits written as 0 leave their latch unchanged.
- R7: A read of offset 0x04 returns {direction at bit 8, function at bits 2:0} of the lowest-numbered selected line. It returns 0 when the mask is 0.
- R8: Reads of offsets 0x10 and 0x14 return 0. Writes to offset 0x08 change no latch, no configuration and no mask.
- R9: pad_oe[n] is 1 exactly when line n has direction 1 and function 0.
- R10: A read of offset 0x08 returns the pad levels after two synchronizer flops. bus_rdata carries every read result in the cycle after the request.
- R11: A configuration write of 0 returns the selected lines to GPIO inputs, clearing the function and the direction together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (5) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after a read request |
| pad_in | input | NLINES (32) | Asynchronous pad levels |
| pad_out | output | NLINES (32) | Output latches |
| pad_oe | output | NLINES (32) | Per-line output enable |
| line_func | output | 3*NLINES (96) | Per-line function selector, 3 bits per line |

## Verification
Configuration, output-latch and mask writes take effect at the clock edge that accepts them. The bench therefore checks pad_out, pad_oe and line_func at the falling edge right after the write. Read data is registered: a scoreboard queue holds the expected word for each read request, and a monitor compares bus_rdata just after the rising edge that captured it. For the pad status, the bench changes pad_in and issues two back-to-back reads. The first read must still return the old level and the second must return the new one, which pins the two-flop delay.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int unsigned FUNC_W  = 3;
    localparam int unsigned DIR_BIT = 8;

    // byte offsets of the registers
    localparam int unsigned OFS_MASK = 'h00;
    localparam int unsigned OFS_CFG  = 'h04;
    localparam int unsigned OFS_STAT = 'h08;
    localparam int unsigned OFS_SET  = 'h10;
    localparam int unsigned OFS_CLR  = 'h14;

    typedef enum logic [FUNC_W-1:0] {
        FN_GPIO = 3'd0,
        FN_ALT_A = 3'd1,
        FN_ALT_B = 3'd2,
        FN_ALT_C = 3'd3,
        FN_ALT_D = 3'd4,
        FN_ALT_E = 3'd5,
        FN_ALT_F = 3'd6,
        FN_ALT_G = 3'd7
    } gpb_func_e;

    typedef struct packed {
        logic      dir;
        gpb_func_e func;
    } gpb_cfg_t;

    localparam gpb_cfg_t CFG_RESET = '{dir: 1'b0, func: FN_GPIO};

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MASK,
        RG_CFG,
        RG_STAT,
        RG_SET,
        RG_CLR
    } gpb_reg_e;

endpackage

// File: rtl/gpb_in_sync.sv
module gpb_in_sync #(
    parameter int unsigned NLINES = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] async_in,
    output logic [NLINES-1:0] sync_out
);

    logic [NLINES-1:0] stage_d [STAGES];
    logic [NLINES-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpb_out_latch.sv
module gpb_out_latch #(
    parameter int unsigned NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [NLINES-1:0] bits,
    output logic [NLINES-1:0] level
);

    logic [NLINES-1:0] level_d;
    logic [NLINES-1:0] level_q;

    always_comb begin
        level_d = level_q;
        if (set_en) begin
            level_d = level_d | bits;
        end
        if (clr_en) begin
            level_d = level_d & ~bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/gpb_line_cfg.sv
module gpb_line_cfg
    import gpb_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        sel_mask,
    input  logic                     wr_en,
    input  gpb_cfg_t                 wr_cfg,
    output logic [NLINES-1:0]        line_dir,
    output logic [NLINES*FUNC_W-1:0] line_func,
    output logic [NLINES-1:0]        line_oe,
    output gpb_cfg_t                 rd_cfg
);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        gpb_cfg_t cfg_d;
        gpb_cfg_t cfg_q;

        always_comb begin
            cfg_d = cfg_q;
            if (wr_en && sel_mask[i]) begin
                cfg_d = wr_cfg;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q <= CFG_RESET;
            end else begin
                cfg_q <= cfg_d;
            end
        end

        assign line_dir[i]                   = cfg_q.dir;
        assign line_func[i*FUNC_W +: FUNC_W] = cfg_q.func;
        assign line_oe[i]                    = cfg_q.dir && (cfg_q.func == FN_GPIO);
    end

    // readback: lowest-numbered selected line wins
    always_comb begin
        rd_cfg = CFG_RESET;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (sel_mask[i]) begin
                rd_cfg.dir  = line_dir[i];
                rd_cfg.func = gpb_func_e'(line_func[i*FUNC_W +: FUNC_W]);
            end
        end
    end

endmodule

// File: rtl/gpb_regif.sv
module gpb_regif
    import gpb_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  gpb_cfg_t          rd_cfg,
    input  logic [NLINES-1:0] pin_status,
    output logic [NLINES-1:0] sel_mask,
    output logic              cfg_wr_en,
    output gpb_cfg_t          cfg_wr_val,
    output logic              set_en,
    output logic              clr_en,
    output logic [NLINES-1:0] line_bits
);

    localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
    localparam logic [AW-1:0] A_CFG  = AW'(OFS_CFG);
    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_SET  = AW'(OFS_SET);
    localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic [DW-1:0]     rdata;
    } regif_state_t;

    regif_state_t st_d;
    regif_state_t st_q;
    gpb_reg_e     target;
    logic         wr_hit;
    logic         rd_hit;
    logic [DW-1:0] rd_word;

    always_comb begin
        unique case (bus_addr)
            A_MASK:  target = RG_MASK;
            A_CFG:   target = RG_CFG;
            A_STAT:  target = RG_STAT;
            A_SET:   target = RG_SET;
            A_CLR:   target = RG_CLR;
            default: target = RG_NONE;
        endcase
    end

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    always_comb begin
        rd_word = '0;
        case (target)
            RG_MASK: rd_word[NLINES-1:0] = st_q.mask;
            RG_CFG: begin
                rd_word[DIR_BIT]      = rd_cfg.dir;
                rd_word[FUNC_W-1:0]   = rd_cfg.func;
            end
            RG_STAT: rd_word[NLINES-1:0] = pin_status;
            default: rd_word = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_hit ? rd_word : '0;
        if (wr_hit && target == RG_MASK) begin
            st_d.mask = bus_wdata[NLINES-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata       = st_q.rdata;
    assign sel_mask        = st_q.mask;
    assign cfg_wr_en       = wr_hit && (target == RG_CFG);
    assign cfg_wr_val.dir  = bus_wdata[DIR_BIT];
    assign cfg_wr_val.func = gpb_func_e'(bus_wdata[FUNC_W-1:0]);
    assign set_en          = wr_hit && (target == RG_SET);
    assign clr_en          = wr_hit && (target == RG_CLR);
    assign line_bits       = bus_wdata[NLINES-1:0];

endmodule

// File: rtl/gpb_bank_top.sv
module gpb_bank_top
    import gpb_pkg::*;
#(
    parameter int unsigned NLINES      = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned AW          = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    input  logic [NLINES-1:0]        pad_in,
    output logic [NLINES-1:0]        pad_out,
    output logic [NLINES-1:0]        pad_oe,
    output logic [NLINES*FUNC_W-1:0] line_func
);

    logic [NLINES-1:0] sel_mask;
    logic              cfg_wr_en;
    gpb_cfg_t          cfg_wr_val;
    gpb_cfg_t          rd_cfg;
    logic              set_en;
    logic              clr_en;
    logic [NLINES-1:0] line_bits;
    logic [NLINES-1:0] line_dir;
    logic [NLINES-1:0] pin_status;

    gpb_regif #(.NLINES(NLINES), .DW(DW), .AW(AW)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .rd_cfg     (rd_cfg),
        .pin_status (pin_status),
        .sel_mask   (sel_mask),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_val (cfg_wr_val),
        .set_en     (set_en),
        .clr_en     (clr_en),
        .line_bits  (line_bits)
    );

    gpb_line_cfg #(.NLINES(NLINES)) u_line_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_mask  (sel_mask),
        .wr_en     (cfg_wr_en),
        .wr_cfg    (cfg_wr_val),
        .line_dir  (line_dir),
        .line_func (line_func),
        .line_oe   (pad_oe),
        .rd_cfg    (rd_cfg)
    );

    gpb_out_latch #(.NLINES(NLINES)) u_out_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_en),
        .clr_en (clr_en),
        .bits   (line_bits),
        .level  (pad_out)
    );

    gpb_in_sync #(.NLINES(NLINES), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_status)
    );

    logic unused_dir;
    assign unused_dir = ^line_dir;

endmodule

// File: rtl/gpb_bank_checker.sv
module gpb_bank_checker
    import gpb_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned DW     = 32,
    parameter int unsigned AW     = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [AW-1:0]            bus_addr,
    input logic [DW-1:0]            bus_wdata,
    input logic [DW-1:0]            bus_rdata,
    input logic [NLINES-1:0]        pad_out,
    input logic [NLINES-1:0]        pad_oe,
    input logic [NLINES*FUNC_W-1:0] line_func
);

    logic              wr_set;
    logic              wr_clr;
    logic              rd_setclr;
    logic [NLINES-1:0] is_gpio;

    assign wr_set    = bus_sel && bus_wr && (bus_addr == AW'(OFS_SET));
    assign wr_clr    = bus_sel && bus_wr && (bus_addr == AW'(OFS_CLR));
    assign rd_setclr = bus_sel && !bus_wr &&
                       ((bus_addr == AW'(OFS_SET)) || (bus_addr == AW'(OFS_CLR)));

    always_comb begin
        for (int i = 0; i < NLINES; i++) begin
            is_gpio[i] = (line_func[i*FUNC_W +: FUNC_W] == '0);
        end
    end

    assert_set_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pad_out == ($past(pad_out) | $past(bus_wdata[NLINES-1:0])));

    assert_clr_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pad_out == ($past(pad_out) & ~$past(bus_wdata[NLINES-1:0])));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pad_out));

    assert_setclr_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_setclr |=> bus_rdata == '0);

    assert_oe_gpio_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~is_gpio) == '0);

endmodule

bind gpb_bank_top gpb_bank_checker #(.NLINES(NLINES), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/test_gpb_bank_top.sv
module test_gpb_bank_top;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic [3*N-1:0] line_func;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpb_bank_top i_gpb_bank_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .line_func (line_func)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: read data is due one cycle after the request
    initial begin
        forever begin
            @(posedge clk);
            if (bus_sel && !bus_wr) begin
                #1;
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 unexpected read actual=%0h expected=none", bus_rdata);
                end else begin
                    check(tag_q.pop_front(), {96'd0, bus_rdata}, {96'd0, exp_q.pop_front()});
                end
            end
        end
    end

    function automatic logic [3*N-1:0] func_all(input logic [2:0] f);
        logic [3*N-1:0] v;
        for (int i = 0; i < N; i++) v[3*i +: 3] = f;
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3*N-1:0] f_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_out", {96'd0, pad_out}, 128'd0);
        check("R1 pad_oe", {96'd0, pad_oe}, 128'd0);
        check("R1 line_func", {32'd0, line_func}, 128'd0);
        check("R1 rdata", {96'd0, bus_rdata}, 128'd0);
        bus_read(5'h00, 32'h0, "R1 mask");
        bus_read(5'h04, 32'h0, "R7 no line selected");

        // R2 mask
        bus_write(5'h00, 32'h0000_0011);
        bus_read(5'h00, 32'h0000_0011, "R2 mask readback");

        // R3 / R9: GPIO output on lines 0 and 4
        bus_write(5'h04, 32'h0000_0100);
        check("R3 R9 oe masked lines", {96'd0, pad_oe}, {96'd0, 32'h0000_0011});
        check("R3 line_func", {32'd0, line_func}, 128'd0);

        // R4: line 4 to function E (code 5), direction stays out
        bus_write(5'h00, 32'h0000_0010);
        bus_write(5'h04, 32'h0000_0105);
        f_exp = '0; f_exp[3*4 +: 3] = 3'd5;
        check("R4 line_func", {32'd0, line_func}, {32'd0, f_exp});
        check("R9 oe dropped for alt function", {96'd0, pad_oe}, {96'd0, 32'h0000_0001});
        bus_read(5'h04, 32'h0000_0105, "R7 single line");

        // R7 lowest selected line wins
        bus_write(5'h00, 32'h0000_0030);
        bus_read(5'h04, 32'h0000_0105, "R7 lowest of 4,5");
        bus_write(5'h00, 32'h8000_0001);
        bus_read(5'h04, 32'h0000_0100, "R7 lowest of 0,31");

        // R11 write 0 returns line 4 to GPIO input
        bus_write(5'h00, 32'h0000_0010);
        bus_write(5'h04, 32'h0000_0000);
        bus_read(5'h04, 32'h0000_0000, "R11 cleared config");
        check("R11 line_func", {32'd0, line_func}, 128'd0);
        check("R11 oe", {96'd0, pad_oe}, {96'd0, 32'h0000_0001});

        // R5 / R6 output latch
        bus_write(5'h10, 32'h0000_00F0);
        check("R5 set", {96'd0, pad_out}, {96'd0, 32'h0000_00F0});
        bus_write(5'h14, 32'h0000_0030);
        check("R6 clear", {96'd0, pad_out}, {96'd0, 32'h0000_00C0});
        bus_write(5'h10, 32'h0000_0000);
        check("R5 zero bits no effect", {96'd0, pad_out}, {96'd0, 32'h0000_00C0});
        bus_write(5'h14, 32'h0000_0000);
        check("R6 zero bits no effect", {96'd0, pad_out}, {96'd0, 32'h0000_00C0});
        bus_write(5'h10, 32'h8000_0001);
        check("R5 edge lines", {96'd0, pad_out}, {96'd0, 32'h8000_00C1});

        // R8 set/clear read zero, status write ignored
        bus_read(5'h10, 32'h0, "R8 set reads 0");
        bus_read(5'h14, 32'h0, "R8 clear reads 0");
        bus_write(5'h08, 32'hFFFF_FFFF);
        check("R8 status write pad_out", {96'd0, pad_out}, {96'd0, 32'h8000_00C1});
        check("R8 status write oe", {96'd0, pad_oe}, {96'd0, 32'h0000_0001});
        bus_read(5'h00, 32'h0000_0010, "R8 status write mask");

        // R10 two-flop synchronizer latency
        @(negedge clk);
        pad_in = 32'hA5C3_0F96;
        bus_read(5'h08, 32'h0000_0000, "R10 status before sync");
        bus_read(5'h08, 32'hA5C3_0F96, "R10 status after sync");
        @(negedge clk);
        pad_in = 32'h0000_0001;
        repeat (2) @(negedge clk);
        bus_read(5'h08, 32'h0000_0001, "R10 status second pattern");

        // R3 all lines at once, then R9 full-width OE
        bus_write(5'h00, 32'hFFFF_FFFF);
        bus_write(5'h04, 32'h0000_0107);
        check("R3 all func G", {32'd0, line_func}, {32'd0, func_all(3'd7)});
        check("R9 no oe for func G", {96'd0, pad_oe}, 128'd0);
        bus_write(5'h04, 32'h0000_0100);
        check("R9 all GPIO outputs", {96'd0, pad_oe}, {96'd0, 32'hFFFF_FFFF});
        bus_write(5'h00, 32'h0000_0000);
        bus_write(5'h04, 32'h0000_0003);
        check("R3 empty mask no change", {96'd0, pad_oe}, {96'd0, 32'hFFFF_FFFF});

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule